// File: doc/BRIEF.md
# Two-Wire Write-Only Trim Register Slave

This block is a slave on a two-wire serial bus. It holds one 8-bit frequency-trim value, and that value drives an external tuning circuit. A fast system clock samples the bus clock and data lines. The block finds start and stop conditions on the synchronized lines. It then receives a device address byte, a register pointer byte and any number of data bytes.

The slave acknowledges each byte it accepts by pulling the data line low for one bus clock period. The data line is open-drain: the block drives only an output enable, and the pad logic turns that into a low level. After each data byte the register pointer advances by one. A data byte lands in the trim value only when the pointer equals the trim address at that moment. The block handles writes only. A read request is not acknowledged.

Top module: `tw_trim_slave`

## Requirements
- R1: When reset is asserted, the `trim` output returns to 0x80 and `sda_oe` is 0.
- R2: The frame start, address byte 0xD2 (device address 1101001 followed by a 0 write bit), pointer 0x13, data byte V, stop leaves `trim` equal to V. This holds for any V from 0x00 to 0xFF. `trim` changes only at the same system clock edge where the acknowledge for that data byte begins.
- R3: The acknowledge works as follows for every accepted byte. `sda_oe` rises while the bus clock is low after the eighth bit, stays high through the ninth clock-high period, and falls after the ninth clock falls.
- R4: An address byte whose upper seven bits differ from 1101001 gets no acknowledge. Until the next start or stop, the slave then acknowledges no further byte and leaves `trim` unchanged.
- R5: An address byte of 0xD3 (matching address with the read bit set to 1) gets no acknowledge. The bytes that follow it leave `trim` unchanged.
- R6: The pointer advances by one after each data byte. Writing pointer 0x12 followed by the data bytes A, B and C puts B into `trim`.
- R7: Data bytes sent to any pointer value other than 0x13 are acknowledged but leave `trim` unchanged.
- R8: A start condition in the middle of a byte drops the partial byte and restarts address reception with the bit count at zero. A complete frame that follows it works as in R2.
- R9: A stop condition returns the slave to idle. Bytes clocked after a stop and before the next start get no acknowledge and leave `trim` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line level, asynchronous |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| trim | output | 8 | Current trim value for the tuning circuit |

## Verification
The bench builds the block with its default parameters: device address 0x69, trim address 0x13, reset value 0x80 and a two-flop synchronizer. Each bus quarter period lasts eight system clocks, so one bus bit spans 32 system clocks. This puts the two-cycle synchronizer delay and the edge detector well inside each bus phase. The same setup brings the 0x12-to-0x13 pointer wrap, the extreme data values 0x00 and 0xFF, and a repeated start that lands mid-byte within reach of a short run.

// File: rtl/tw_trim_slave.sv
module tw_trim_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [7:0] TRIM_ADDR = 8'h13,
  parameter logic [7:0] TRIM_INIT = 8'h80,
  parameter int         SYNC      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] trim
);

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_ADDR = 3'd1;
  localparam logic [2:0] ST_REG  = 3'd2;
  localparam logic [2:0] ST_DATA = 3'd3;
  localparam logic [2:0] ST_SKIP = 3'd4;
  localparam logic [7:0] WR_ADDR = {DEV_ADDR, 1'b0};

  logic [SYNC-1:0] scl_sr, sda_sr;
  logic            scl_d, sda_d;
  logic            scl_q, sda_q;
  logic            scl_rise, scl_fall, start_det, stop_det;
  logic [2:0]      state;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg, ptr;
  logic            in_ack;
  logic            receiving;

  assign scl_q     = scl_sr[SYNC-1];
  assign sda_q     = sda_sr[SYNC-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
  assign receiving = (state == ST_ADDR) || (state == ST_REG) || (state == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC-2:0], sda_i};
      scl_d  <= scl_q;
      sda_d  <= sda_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
      trim   <= TRIM_INIT;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (receiving) begin
      if (scl_rise && !in_ack && bitcnt != 4'd8) begin
        shreg  <= {shreg[6:0], sda_q};
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          sda_oe <= 1'b0;
          bitcnt <= '0;
        end else if (bitcnt == 4'd8) begin
          case (state)
            ST_ADDR: begin
              if (shreg == WR_ADDR) begin
                state  <= ST_REG;
                sda_oe <= 1'b1;
                in_ack <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_REG: begin
              ptr    <= shreg;
              state  <= ST_DATA;
              sda_oe <= 1'b1;
              in_ack <= 1'b1;
            end
            default: begin
              if (ptr == TRIM_ADDR) trim <= shreg;
              ptr    <= ptr + 8'd1;
              sda_oe <= 1'b1;
              in_ack <= 1'b1;
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/tw_trim_chk.sv
module tw_trim_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_q,
  input logic       start_det,
  input logic       sda_oe,
  input logic [7:0] trim,
  input logic [2:0] state,
  input logic [3:0] bitcnt
);

  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_ADDR = 3'd1;
  localparam logic [2:0] C_SKIP = 3'd4;

  // R3
  ack_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_q));

  // R2
  trim_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(trim) |-> sda_oe);

  // R4
  skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_SKIP) |-> !sda_oe);

  // R9
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_IDLE) |-> !sda_oe);

  // R8
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == C_ADDR && bitcnt == 4'd0 && !sda_oe));

endmodule

bind tw_trim_slave tw_trim_chk u_tw_trim_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_q     (scl_q),
  .start_det (start_det),
  .sda_oe    (sda_oe),
  .trim      (trim),
  .state     (state),
  .bitcnt    (bitcnt)
);

// File: tb/test_tw_trim_slave.sv
module test_tw_trim_slave;

  localparam int Q = 8;
  localparam int NV = 7;
  // {address byte, pointer, data, expected ack, expected trim after frame}
  localparam logic [32:0] VEC [NV] = '{
    {8'hD2, 8'h13, 8'h3C, 1'b1, 8'h3C},
    {8'hD2, 8'h14, 8'h55, 1'b1, 8'h3C},
    {8'hA4, 8'h13, 8'h11, 1'b0, 8'h3C},
    {8'hD3, 8'h13, 8'h22, 1'b0, 8'h3C},
    {8'hD2, 8'h13, 8'hFF, 1'b1, 8'hFF},
    {8'hD2, 8'h13, 8'h00, 1'b1, 8'h00},
    {8'hD2, 8'h12, 8'h77, 1'b1, 8'h00}
  };
  localparam string VREQ [NV] = '{"R2", "R7", "R4", "R5", "R2", "R2", "R7"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [7:0] trim;
  logic sda_line;
  logic rel_oe;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  tw_trim_slave i_tw_trim_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .trim(trim)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; q(); sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    ack = ~sda_line;
    q(); scl_m = 1'b0; q();
    rel_oe = sda_oe;
  endtask

  task automatic byte_exp(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    send_byte(b, a);
    chk(req, {31'd0, a}, {31'd0, exp_ack});
    if (exp_ack) chk("R3", {31'd0, rel_oe}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", {24'd0, trim}, 32'h80);
    chk("R1", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      bus_start();
      byte_exp(VEC[v][32:25], VEC[v][8], "R3");
      byte_exp(VEC[v][24:17], VEC[v][8], VREQ[v]);
      byte_exp(VEC[v][16:9], VEC[v][8], VREQ[v]);
      bus_stop();
      chk(VREQ[v], {24'd0, trim}, {24'd0, VEC[v][7:0]});
    end

    // R6: pointer advance across the trim address
    bus_start();
    byte_exp(8'hD2, 1'b1, "R6");
    byte_exp(8'h12, 1'b1, "R6");
    byte_exp(8'hAA, 1'b1, "R6");
    chk("R6", {24'd0, trim}, 32'h00);
    byte_exp(8'h5B, 1'b1, "R6");
    byte_exp(8'h99, 1'b1, "R6");
    bus_stop();
    chk("R6", {24'd0, trim}, 32'h5B);

    // R8: repeated start mid data byte
    bus_start();
    byte_exp(8'hD2, 1'b1, "R8");
    byte_exp(8'h13, 1'b1, "R8");
    send_bits(8'hE7, 4);
    bus_start();
    byte_exp(8'hD2, 1'b1, "R8");
    byte_exp(8'h13, 1'b1, "R8");
    byte_exp(8'hC4, 1'b1, "R8");
    bus_stop();
    chk("R8", {24'd0, trim}, 32'hC4);

    // R8: repeated start mid address byte
    bus_start();
    send_bits(8'h25, 3);
    bus_start();
    byte_exp(8'hD2, 1'b1, "R8");
    byte_exp(8'h13, 1'b1, "R8");
    byte_exp(8'h3A, 1'b1, "R8");
    bus_stop();
    chk("R8", {24'd0, trim}, 32'h3A);

    // R9: bytes after a stop with no new start
    byte_exp(8'hD2, 1'b0, "R9");
    byte_exp(8'h13, 1'b0, "R9");
    byte_exp(8'h66, 1'b0, "R9");
    chk("R9", {24'd0, trim}, 32'h3A);

    // R1: reset during operation
    bus_stop();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", {24'd0, trim}, 32'h80);
    chk("R1", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule